// File: doc/BRIEF.md
# Nibble-Bus Memory Read Target

This block sits on the target side of a 4-bit multiplexed host bus in the LPC family. It is clocked by the 33 MHz bus clock. It watches the framing strobe and the nibble present while the strobe is low, and from that nibble it recognises one of two read framings. The first is the firmware-hub style, which carries a chip-select nibble, a 28-bit address and a size code. The second is the plain LPC memory read, which carries a cycle-type nibble and a 32-bit address. No static mode pin is involved.

Once a read header has been accepted, the block fetches the requested bytes through a simple request/ready memory port and stores them in a small local buffer. It waits out the two turnaround cycles, then takes the bus. It drives wait-sync nibbles until the data is ready, then one ready-sync nibble, then the data nibbles. It ends with a closing turnaround and releases the bus.

Reads that are not addressed to this target are ignored. A fresh strobe in the middle of a transfer cancels the transfer at once.

Top module: `lpc_read_target`

## Requirements
- R1: Following reset, the bus drive enable and the memory request are both low.
- R2: With the strobe low, nibble 1101b opens a hub-style read. The next nibbles are, in order: a select nibble, seven address nibbles (most significant first) and a size nibble n. The block returns 2^n bytes read from consecutive memory addresses, starting at the low ADDR_W bits of the address.
- R3: With the strobe low, nibble 0000b opens an LPC read. It is followed by a cycle-type nibble whose upper three bits are 010b, then eight address nibbles (most significant first). The block returns exactly one byte.
- R4: A hub-style read whose select nibble differs from the id_strap input is ignored: the bus is never driven and no memory request is made.
- R5: An LPC header whose cycle-type nibble does not have 010b in its upper three bits is ignored. So is any start nibble other than 1101b or 0000b.
- R6: The block leaves the bus undriven for the whole header and for both turnaround cycles. It begins driving in the cycle right after the second turnaround, and the first nibble it drives is the wait-sync code 0101b.
- R7: Before data, the block drives at least two wait-sync nibbles (0101b), extends the wait while the memory is slow, and then drives exactly one ready-sync nibble (0000b). A one-byte read whose memory answers in the cycle after the request gets exactly two wait-sync nibbles.
- R8: Data follows the ready-sync nibble as two nibbles per byte, low nibble first, with bytes in ascending address order.
- R9: After the last data nibble, the block drives 1111b for one cycle and then releases the bus.
- R10: Sampling the strobe low at any clock edge releases the bus and drops the memory request in the following cycle. The nibble sampled in that cycle is decoded as a new start nibble.
- R11: A hub-style size nibble greater than MAX_SIZE_LOG2 causes the read to be ignored.
- R12: The memory request stays high with a stable address until ready is seen. Once the last byte has been taken, the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | 1 | Framing strobe, active low |
| bus_lad_i | input | 4 | Nibble sampled from the shared bus |
| bus_lad_o | output | 4 | Nibble driven onto the shared bus |
| bus_lad_oe | output | 1 | Drive enable for bus_lad_o |
| id_strap | input | 4 | Strapped chip-select value for hub-style reads |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_ready | input | 1 | Memory data valid for the current request |
| mem_rdata | input | 8 | Memory read data |

## Verification
Several properties are checked by assertions on every clock. The first driven nibble is always a wait-sync. The ready-sync is always preceded by two wait-sync nibbles, and data is never sent before the fetch completes. A sampled strobe always releases the bus one cycle later. The drive enable only falls after a 1111b nibble unless the transfer was aborted. A pending memory request holds its address until ready is seen.

Other behaviour can only be shown by the bench's scenarios, because it depends on matching the whole header against the returned data:
- the header decode;
- select and cycle-type filtering;
- size rejection;
- nibble and byte ordering;
- the exact count of wait-sync nibbles under a fast memory;
- restart after an abort.

// File: rtl/lpcrt_pkg.sv
package lpcrt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IDSEL,
    ST_CTYPE,
    ST_ADDR,
    ST_MSIZE,
    ST_TAR1,
    ST_TAR2,
    ST_SYNC,
    ST_DATA,
    ST_TEND
  } rd_state_e;

  typedef enum logic {
    KIND_HUB,
    KIND_LPC
  } cyc_kind_e;

  localparam logic [3:0] NIB_START_HUB = 4'hD;
  localparam logic [3:0] NIB_START_LPC = 4'h0;
  localparam logic [3:0] NIB_WSYNC     = 4'h5;
  localparam logic [3:0] NIB_RSYNC     = 4'h0;
  localparam logic [3:0] NIB_TAR       = 4'hF;
  localparam logic [2:0] CT_MEMRD_HI   = 3'b010;
  localparam logic [3:0] HUB_ADDR_LAST = 4'd6;
  localparam logic [3:0] LPC_ADDR_LAST = 4'd7;

endpackage

// File: rtl/lpcrt_fetch.sv
module lpcrt_fetch #(
  parameter int ADDR_W   = 20,
  parameter int MAX_LOG2 = 2,
  localparam int IDXW    = (MAX_LOG2 > 0) ? MAX_LOG2 : 1,
  localparam int DEPTH   = 1 << IDXW,
  localparam int CW      = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [3:0]        size_log2_i,
  input  logic              cancel_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  input  logic [IDXW-1:0]   rd_idx_i,
  output logic [7:0]        rd_byte_o
);

  logic [CW-1:0] widx;
  logic [CW-1:0] nbytes_q;
  logic [CW-1:0] nbytes_d;
  logic          take;
  logic [7:0]    byte_buf [DEPTH];

  assign nbytes_d = CW'(1) << size_log2_i;
  assign take     = mem_req_o && mem_ready_i && !cancel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      widx       <= '0;
      nbytes_q   <= '0;
      done_o     <= 1'b0;
    end else if (cancel_i) begin
      mem_req_o <= 1'b0;
      done_o    <= 1'b0;
    end else if (start_i) begin
      mem_req_o  <= 1'b1;
      mem_addr_o <= base_i;
      widx       <= '0;
      nbytes_q   <= nbytes_d;
      done_o     <= 1'b0;
    end else if (take) begin
      widx       <= widx + 1'b1;
      mem_addr_o <= mem_addr_o + 1'b1;
      if (widx == nbytes_q - 1'b1) begin
        mem_req_o <= 1'b0;
        done_o    <= 1'b1;
      end
    end
  end

  // Byte buffer: single write port, no reset, so it maps to distributed RAM.
  always_ff @(posedge clk) begin
    if (take) byte_buf[widx[IDXW-1:0]] <= mem_rdata_i;
  end

  assign rd_byte_o = byte_buf[rd_idx_i];

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i && !cancel_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R12
  done_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(mem_ready_i));

endmodule

// File: rtl/lpcrt_ctrl.sv
module lpcrt_ctrl
  import lpcrt_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MAX_LOG2 = 2,
  localparam int IDXW    = (MAX_LOG2 > 0) ? MAX_LOG2 : 1,
  localparam int NW      = IDXW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n_i,
  input  logic [3:0]        lad_i,
  input  logic [3:0]        id_strap_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              fetch_start_o,
  output logic [ADDR_W-1:0] fetch_base_o,
  output logic [3:0]        fetch_size_o,
  output logic              fetch_cancel_o,
  input  logic              fetch_done_i,
  output logic [IDXW-1:0]   rd_idx_o,
  input  logic [7:0]        rd_byte_i
);

  localparam logic [3:0] MAX_SZ = 4'(MAX_LOG2);

  rd_state_e         state;
  cyc_kind_e         kind;
  logic [3:0]        hdr_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [ADDR_W-1:0] addr_next;
  logic [3:0]        size_q;
  logic [1:0]        wcnt;
  logic [NW-1:0]     nidx;
  logic [NW-1:0]     nnib;
  logic [3:0]        addr_last;
  logic              lpc_hdr_end;
  logic              hub_size_ok;

  assign addr_next   = {addr_sh[ADDR_W-5:0], lad_i};
  assign addr_last   = (kind == KIND_HUB) ? HUB_ADDR_LAST : LPC_ADDR_LAST;
  assign nnib        = NW'(2) << size_q;
  assign lpc_hdr_end = (state == ST_ADDR) && (kind == KIND_LPC) && (hdr_cnt == addr_last);
  assign hub_size_ok = (lad_i <= MAX_SZ);

  assign fetch_cancel_o = !frame_n_i;
  assign fetch_start_o  = frame_n_i &&
                          (lpc_hdr_end || ((state == ST_MSIZE) && hub_size_ok));
  assign fetch_base_o   = (state == ST_MSIZE) ? addr_sh : addr_next;
  assign fetch_size_o   = (state == ST_MSIZE) ? lad_i : 4'd0;
  assign rd_idx_o       = nidx[IDXW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= KIND_HUB;
      hdr_cnt  <= '0;
      addr_sh  <= '0;
      size_q   <= '0;
      wcnt     <= '0;
      nidx     <= '0;
      lad_o    <= NIB_TAR;
      lad_oe_o <= 1'b0;
    end else if (!frame_n_i) begin
      lad_oe_o <= 1'b0;
      lad_o    <= NIB_TAR;
      addr_sh  <= '0;
      hdr_cnt  <= '0;
      if (lad_i == NIB_START_HUB) begin
        state <= ST_IDSEL;
        kind  <= KIND_HUB;
      end else if (lad_i == NIB_START_LPC) begin
        state <= ST_CTYPE;
        kind  <= KIND_LPC;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_IDSEL: state <= (lad_i == id_strap_i) ? ST_ADDR : ST_IDLE;
        ST_CTYPE: state <= (lad_i[3:1] == CT_MEMRD_HI) ? ST_ADDR : ST_IDLE;
        ST_ADDR: begin
          addr_sh <= addr_next;
          hdr_cnt <= hdr_cnt + 1'b1;
          if (hdr_cnt == addr_last) begin
            if (kind == KIND_HUB) begin
              state <= ST_MSIZE;
            end else begin
              state  <= ST_TAR1;
              size_q <= '0;
            end
          end
        end
        ST_MSIZE: begin
          if (hub_size_ok) begin
            size_q <= lad_i;
            state  <= ST_TAR1;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_TAR1: state <= ST_TAR2;
        ST_TAR2: begin
          state    <= ST_SYNC;
          lad_oe_o <= 1'b1;
          lad_o    <= NIB_WSYNC;
          wcnt     <= 2'd1;
        end
        ST_SYNC: begin
          if (wcnt == 2'd2 && fetch_done_i) begin
            lad_o <= NIB_RSYNC;
            state <= ST_DATA;
            nidx  <= '0;
          end else begin
            lad_o <= NIB_WSYNC;
            if (wcnt != 2'd2) wcnt <= wcnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (nidx == nnib) begin
            lad_o <= NIB_TAR;
            state <= ST_TEND;
          end else begin
            lad_o <= nidx[0] ? rd_byte_i[7:4] : rd_byte_i[3:0];
            nidx  <= nidx + 1'b1;
          end
        end
        ST_TEND: begin
          lad_oe_o <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  first_drive_wsync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe_o) |-> (lad_o == NIB_WSYNC));

  // R7
  rsync_after_two_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && nidx == '0) |->
      (lad_o == NIB_RSYNC && $past(lad_o) == NIB_WSYNC &&
       $past(lad_o, 2) == NIB_WSYNC && $past(lad_oe_o, 2)));

  // R8
  data_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> fetch_done_i);

  // R9
  close_tar_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(lad_oe_o) && $past(frame_n_i)) |-> ($past(lad_o) == NIB_TAR));

  // R10
  abort_float_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n_i |=> !lad_oe_o);

endmodule

// File: rtl/lpc_read_target.sv
module lpc_read_target #(
  parameter int ADDR_W        = 20,
  parameter int MAX_SIZE_LOG2 = 2,
  localparam int IDXW         = (MAX_SIZE_LOG2 > 0) ? MAX_SIZE_LOG2 : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_frame_n,
  input  logic [3:0]        bus_lad_i,
  output logic [3:0]        bus_lad_o,
  output logic              bus_lad_oe,
  input  logic [3:0]        id_strap,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata
);

  logic              f_start;
  logic [ADDR_W-1:0] f_base;
  logic [3:0]        f_size;
  logic              f_cancel;
  logic              f_done;
  logic [IDXW-1:0]   f_idx;
  logic [7:0]        f_byte;

  lpcrt_ctrl #(
    .ADDR_W   (ADDR_W),
    .MAX_LOG2 (MAX_SIZE_LOG2)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .frame_n_i      (bus_frame_n),
    .lad_i          (bus_lad_i),
    .id_strap_i     (id_strap),
    .lad_o          (bus_lad_o),
    .lad_oe_o       (bus_lad_oe),
    .fetch_start_o  (f_start),
    .fetch_base_o   (f_base),
    .fetch_size_o   (f_size),
    .fetch_cancel_o (f_cancel),
    .fetch_done_i   (f_done),
    .rd_idx_o       (f_idx),
    .rd_byte_i      (f_byte)
  );

  lpcrt_fetch #(
    .ADDR_W   (ADDR_W),
    .MAX_LOG2 (MAX_SIZE_LOG2)
  ) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .start_i     (f_start),
    .base_i      (f_base),
    .size_log2_i (f_size),
    .cancel_i    (f_cancel),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .mem_ready_i (mem_ready),
    .mem_rdata_i (mem_rdata),
    .done_o      (f_done),
    .rd_idx_i    (f_idx),
    .rd_byte_o   (f_byte)
  );

endmodule

// File: tb/lpc_read_target_tb.sv
`timescale 1ns/1ps
module lpc_read_target_tb;

  localparam int AW = 20;
  localparam int ML = 2;
  localparam logic [3:0] MY_ID = 4'hA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_n = 1'b1;
  logic [3:0]    lad_in = 4'hF;
  logic [3:0]    lad_out;
  logic          lad_oe;
  logic [3:0]    id_strap = MY_ID;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ready;
  logic [7:0]    mem_rdata;

  int checks = 0;
  int fails  = 0;
  int lat_max = 0;
  int lat_cnt = 0;

  always #2.5 clk = ~clk;

  lpc_read_target #(.ADDR_W(AW), .MAX_SIZE_LOG2(ML)) u_dut (
    .clk(clk), .rst(rst), .bus_frame_n(frame_n), .bus_lad_i(lad_in),
    .bus_lad_o(lad_out), .bus_lad_oe(lad_oe), .id_strap(id_strap),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], a[3:0]} ^ 8'h3C;
  endfunction

  assign mem_rdata = memf(mem_addr);

  // memory model: ready after 0..lat_max extra cycles, one pulse per byte
  always @(negedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      lat_cnt   <= 0;
    end else if (mem_ready || !mem_req) begin
      mem_ready <= 1'b0;
      lat_cnt   <= (lat_max == 0) ? 0 : int'($urandom_range(lat_max, 0));
    end else if (lat_cnt == 0) begin
      mem_ready <= 1'b1;
    end else begin
      lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic fr, input logic [3:0] n);
    frame_n = fr;
    lad_in  = n;
    tick();
  endtask

  // start: start nibble; sel: select (hub) or cycle type (LPC); sz: size nibble (hub)
  task automatic do_read(input logic [3:0] start, input logic [3:0] sel,
                         input logic [31:0] addr, input logic [3:0] sz,
                         input bit resp, input bit exact, input string tag);
    bit hub = (start == 4'hD);
    bit float_ok = 1'b1;
    int nb = 1 << sz;
    int wc = 0;
    bit dok = 1'b1;
    int bad_a = 0, bad_e = 0;
    logic [3:0] expn;
    logic [7:0] eb;
    drive(1'b0, start); float_ok &= !lad_oe;
    drive(1'b1, sel);   float_ok &= !lad_oe;
    if (hub) begin
      for (int i = 6; i >= 0; i--) begin drive(1'b1, addr[i*4 +: 4]); float_ok &= !lad_oe; end
      drive(1'b1, sz); float_ok &= !lad_oe;
    end else begin
      nb = 1;
      for (int i = 7; i >= 0; i--) begin drive(1'b1, addr[i*4 +: 4]); float_ok &= !lad_oe; end
    end
    drive(1'b1, 4'hF); float_ok &= !lad_oe;
    drive(1'b1, 4'hF);
    if (!resp) begin
      bit quiet = !lad_oe && !mem_req;
      for (int i = 0; i < 20; i++) begin tick(); quiet &= !lad_oe && !mem_req; end
      chk(quiet, tag, "ignored read stays off bus and memory", int'(lad_oe), 0);
      tick();
      return;
    end
    chk(float_ok, "R6", "undriven through header and turnaround", 0, 0);
    chk(lad_oe && lad_out == 4'h5, "R6", "first driven nibble", int'(lad_out), 5);
    while (lad_oe && lad_out == 4'h5 && wc < 60) begin wc++; tick(); end
    chk(lad_oe && lad_out == 4'h0 && wc >= 2 && (!exact || wc == 2),
        "R7", "wait-sync count then ready-sync", wc, 2);
    tick();
    for (int b = 0; b < nb; b++) begin
      eb = memf(addr[AW-1:0] + AW'(b));
      for (int h = 0; h < 2; h++) begin
        expn = h ? eb[7:4] : eb[3:0];
        if (dok && !(lad_oe && lad_out == expn)) begin
          dok = 1'b0; bad_a = int'(lad_out); bad_e = int'(expn);
        end
        tick();
      end
    end
    chk(dok, hub ? "R2 R8" : "R3 R8", "data nibbles", bad_a, bad_e);
    chk(lad_oe && lad_out == 4'hF, "R9", "closing turnaround nibble", int'(lad_out), 15);
    tick();
    chk(!lad_oe, "R9", "bus released after turnaround", int'(lad_oe), 0);
    chk(!mem_req, "R12", "request low after transfer", int'(mem_req), 0);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) tick();
    rst = 1'b0;
    tick();
    chk(!lad_oe, "R1", "drive enable after reset", int'(lad_oe), 0);
    chk(!mem_req, "R1", "memory request after reset", int'(mem_req), 0);

    // directed: fast memory, exact sync
    lat_max = 0;
    do_read(4'hD, MY_ID, 32'h0123_4567, 4'd0, 1'b1, 1'b1, "R2");
    do_read(4'h0, 4'h4, 32'hDEAD_BEEF, 4'd0, 1'b1, 1'b1, "R3");
    do_read(4'h0, 4'h5, 32'h0000_FFFF, 4'd0, 1'b1, 1'b1, "R3");
    do_read(4'hD, MY_ID, 32'h00F_FFFE, 4'd2, 1'b1, 1'b0, "R2");
    // ignored cycles
    do_read(4'hD, 4'h3, 32'h0001_0000, 4'd0, 1'b0, 1'b0, "R4");
    do_read(4'h0, 4'h6, 32'h0001_0000, 4'd0, 1'b0, 1'b0, "R5");
    do_read(4'h2, 4'h4, 32'h0001_0000, 4'd0, 1'b0, 1'b0, "R5");
    do_read(4'hD, MY_ID, 32'h0001_0000, 4'd3, 1'b0, 1'b0, "R11");
    // slow memory stretches wait-sync
    lat_max = 3;
    do_read(4'hD, MY_ID, 32'h0004_4440, 4'd1, 1'b1, 1'b0, "R7");

    // abort in the middle of sync
    drive(1'b0, 4'hD); drive(1'b1, MY_ID);
    for (int i = 0; i < 7; i++) drive(1'b1, 4'h1);
    drive(1'b1, 4'd2); drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    chk(lad_oe, "R10", "driving before abort", int'(lad_oe), 1);
    drive(1'b0, 4'hF);
    chk(!lad_oe && !mem_req, "R10", "abort releases bus and request",
        int'({lad_oe, mem_req}), 0);
    drive(1'b1, 4'hF);
    // abort during a header, then restart with a new start nibble
    drive(1'b0, 4'hD); drive(1'b1, MY_ID); drive(1'b1, 4'h7);
    do_read(4'h0, 4'h4, 32'h1234_5678, 4'd0, 1'b1, 1'b0, "R10");

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a = $urandom();
      int pick = int'($urandom_range(9, 0));
      lat_max = int'($urandom_range(3, 0));
      if (pick < 5) begin
        logic [3:0] s = 4'($urandom_range(2, 0));
        logic [3:0] id = (pick == 0) ? (MY_ID ^ 4'h5) : MY_ID;
        if (pick == 1) s = 4'd3;
        do_read(4'hD, id, {4'h0, a[27:0]}, s, (pick > 1), 1'b0,
                (pick == 0) ? "R4" : (pick == 1) ? "R11" : "R2");
      end else begin
        logic [3:0] ct = (pick == 9) ? 4'hA : {3'b010, a[0]};
        do_read(4'h0, ct, a, 4'd0, (pick != 9), 1'b0, (pick == 9) ? "R5" : "R3");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule